// File: doc/BRIEF.md
# Conversion Window Watchdog

This block sits beside an analog-to-digital converter's sequencers. It checks each converted value as it appears and compares it against a programmed window. Every result arrives as a one-cycle strobe with the raw 12-bit code, the 5-bit channel number and a tag that marks it as a regular-group or an injected-group conversion. The comparison uses the raw code before any left or right alignment, so both bounds are 12-bit values.

Software sets the window through a small write port. That port holds the upper and lower bounds, separate enables for the two groups, a mode that monitors all channels or one chosen channel, and an interrupt enable. When an enabled, monitored result lies strictly above the upper bound or strictly below the lower bound, a sticky out-of-window flag is raised. The flag stays set until software writes zero to it. The interrupt output is the flag gated by the interrupt enable, as a level.

Write port map: `cfg_sel` 0 is control, with bit 0 the regular enable, bit 1 the injected enable, bit 2 single-channel mode, bit 3 the interrupt enable and bits 8:4 the channel number. `cfg_sel` 1 is the upper bound. `cfg_sel` 2 is the lower bound. `cfg_sel` 3 is status, where bit 0 written as zero clears the flag. A write takes effect for results sampled from the next clock edge on.

Top module: `awd_monitor`

## Requirements
- R1: After reset the flag and interrupt are low, both group enables, single-channel mode and the interrupt enable are off, the channel is 0, the upper bound is 0xFFF and the lower bound is 0.
- R2: A result strobe whose code is greater than the upper bound or less than the lower bound, on an enabled and monitored result, sets the flag at the next clock edge.
- R3: A code equal to the upper bound or equal to the lower bound is inside the window and does not set the flag.
- R4: A bound write takes `cfg_wdata[11:0]`; bits 15:12 of the write data are ignored.
- R5: A regular result (`res_inj`=0) is checked only when control bit 0 is set; an injected result (`res_inj`=1) is checked only when control bit 1 is set; with neither bit set no result sets the flag.
- R6: With control bit 2 clear all channels are monitored; with it set only results whose channel equals control bits 8:4 are monitored, and the same channel number applies to both groups.
- R7: A control write whose bits 8:4 exceed 18 stores channel 0.
- R8: The flag stays set until a status write with bit 0 equal to 0; a status write with bit 0 equal to 1 leaves it unchanged; a new violation in the same cycle as a clearing write keeps the flag set.
- R9: `wd_irq` is high exactly while the flag is set and control bit 3 is set.
- R10: When `res_valid` is low the result inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 upper bound, 2 lower bound, 3 status |
| cfg_wdata | input | 16 | Write data |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 12 | Raw conversion code |
| res_chan | input | 5 | Channel of the result |
| res_inj | input | 1 | 1 = injected group, 0 = regular group |
| wd_flag | output | 1 | Sticky out-of-window flag |
| wd_irq | output | 1 | Interrupt level: flag gated by its enable |

## Verification
The block's only state is its configuration and the flag. A wrong bound, enable or channel register therefore shows as a flag that rises or stays low one edge after a result that lies on one side of it. A lost or spurious clear shows on `wd_flag` on the edge after the status write. The bench picks codes right at the bounds and at one step past them, and channels on and off the selected one, so that such a fault shows in the cycle that follows. It sends both groups with each enable combination and clears the flag between checks, so every check starts from a known flag.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int AWD_DATA_W = 12;
  localparam int AWD_CHAN_W = 5;
  localparam int AWD_SEL_W  = 2;

  localparam logic [AWD_SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [AWD_SEL_W-1:0] SEL_HIGH = 2'd1;
  localparam logic [AWD_SEL_W-1:0] SEL_LOW  = 2'd2;
  localparam logic [AWD_SEL_W-1:0] SEL_STAT = 2'd3;

  localparam int CTL_REG_BIT  = 0;
  localparam int CTL_INJ_BIT  = 1;
  localparam int CTL_ONE_BIT  = 2;
  localparam int CTL_IRQ_BIT  = 3;
  localparam int CTL_CHAN_LSB = 4;

  typedef struct packed {
    logic                  reg_en;
    logic                  inj_en;
    logic                  one_chan;
    logic                  irq_en;
    logic [AWD_CHAN_W-1:0] chan;
    logic [AWD_DATA_W-1:0] upper;
    logic [AWD_DATA_W-1:0] lower;
  } awd_cfg_t;
endpackage

// File: rtl/awd_cfg_regs.sv
module awd_cfg_regs
  import awd_pkg::*;
#(
  parameter int WDATA_W  = 16,
  parameter int CHAN_MAX = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [AWD_SEL_W-1:0] sel,
  input  logic [WDATA_W-1:0]   wdata,
  output awd_cfg_t             cfg
);
  localparam int CHAN_MSB = CTL_CHAN_LSB + AWD_CHAN_W - 1;
  localparam logic [AWD_CHAN_W-1:0] CHAN_LIMIT = AWD_CHAN_W'(CHAN_MAX);

  awd_cfg_t cfg_q, cfg_d;
  logic [AWD_CHAN_W-1:0] chan_wr;

  always_comb begin
    chan_wr = wdata[CHAN_MSB:CTL_CHAN_LSB];
    cfg_d   = cfg_q;
    if (wr) begin
      case (sel)
        SEL_CTRL: begin
          cfg_d.reg_en   = wdata[CTL_REG_BIT];
          cfg_d.inj_en   = wdata[CTL_INJ_BIT];
          cfg_d.one_chan = wdata[CTL_ONE_BIT];
          cfg_d.irq_en   = wdata[CTL_IRQ_BIT];
          cfg_d.chan     = (chan_wr > CHAN_LIMIT) ? '0 : chan_wr;
        end
        SEL_HIGH: cfg_d.upper = wdata[AWD_DATA_W-1:0];
        SEL_LOW:  cfg_d.lower = wdata[AWD_DATA_W-1:0];
        default:  cfg_d = cfg_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.reg_en   <= 1'b0;
      cfg_q.inj_en   <= 1'b0;
      cfg_q.one_chan <= 1'b0;
      cfg_q.irq_en   <= 1'b0;
      cfg_q.chan     <= '0;
      cfg_q.upper    <= '1;
      cfg_q.lower    <= '0;
    end else if (wr) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  // R7: stored channel never exceeds the highest legal number
  assert_chan_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.chan <= CHAN_LIMIT);
endmodule

// File: rtl/awd_window_cmp.sv
module awd_window_cmp
  import awd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  awd_cfg_t              cfg,
  input  logic                  valid,
  input  logic [AWD_DATA_W-1:0] code,
  input  logic [AWD_CHAN_W-1:0] chan,
  input  logic                  inj,
  output logic                  hit
);
  logic group_on, chan_on, outside;

  always_comb begin
    group_on = inj ? cfg.inj_en : cfg.reg_en;
    chan_on  = !cfg.one_chan || (chan == cfg.chan);
    outside  = (code > cfg.upper) || (code < cfg.lower);
    hit      = valid && group_on && chan_on && outside;
  end

  // R10: no strobe, no violation
  assert_idle_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !hit);
  // R5: both groups disabled keeps the comparator silent
  assert_groups_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.reg_en && !cfg.inj_en) |-> !hit);
endmodule

// File: rtl/awd_flag.sv
module awd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (hit)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q && irq_en;

  // R8: flag holds unless a clear arrives
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  // R8: a violation beats a simultaneous clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr) |=> flag_q);
endmodule

// File: rtl/awd_monitor.sv
module awd_monitor
  import awd_pkg::*;
#(
  parameter int WDATA_W  = 16,
  parameter int CHAN_MAX = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [AWD_SEL_W-1:0]  cfg_sel,
  input  logic [WDATA_W-1:0]    cfg_wdata,
  input  logic                  res_valid,
  input  logic [AWD_DATA_W-1:0] res_data,
  input  logic [AWD_CHAN_W-1:0] res_chan,
  input  logic                  res_inj,
  output logic                  wd_flag,
  output logic                  wd_irq
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  awd_cfg_t   cfg;
  logic       hit, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  awd_cfg_regs #(.WDATA_W(WDATA_W), .CHAN_MAX(CHAN_MAX)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr(cfg_wr), .sel(cfg_sel),
    .wdata(cfg_wdata), .cfg(cfg));

  awd_window_cmp u_cmp (
    .clk(clk), .rst_n(rst_int_n), .cfg(cfg), .valid(res_valid),
    .code(res_data), .chan(res_chan), .inj(res_inj), .hit(hit));

  assign clr = cfg_wr && (cfg_sel == SEL_STAT) && !cfg_wdata[0];

  awd_flag u_flag (
    .clk(clk), .rst_n(rst_int_n), .hit(hit), .clr(clr),
    .irq_en(cfg.irq_en), .flag(wd_flag), .irq(wd_irq));

  // R2: a violation is visible on the flag at the following edge
  assert_hit_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    hit |=> wd_flag);
  // R9: interrupt never asserts without the flag
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    wd_irq |-> wd_flag);
endmodule

// File: tb/tb_awd_monitor.sv
module tb_awd_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic        res_valid;
  logic [11:0] res_data;
  logic [4:0]  res_chan;
  logic        res_inj;
  logic        wd_flag, wd_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural model state
  int m_hi, m_lo, m_chan;
  bit m_reg, m_inj, m_one, m_irq, m_flag;

  always #10 clk = ~clk;

  awd_monitor dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .res_inj(res_inj), .wd_flag(wd_flag), .wd_irq(wd_irq));

  task automatic check(input string req, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit wr, input int sel, input int data,
                       input bit v, input int code, input int ch, input bit inj,
                       input string req);
    bit hit;
    int cf;
    @(negedge clk);
    cfg_wr = wr; cfg_sel = 2'(sel); cfg_wdata = 16'(data);
    res_valid = v; res_data = 12'(code); res_chan = 5'(ch); res_inj = inj;
    @(posedge clk);
    #1;
    hit = v && (inj ? m_inj : m_reg) && (!m_one || ch == m_chan)
          && (code > m_hi || code < m_lo);
    if (hit) m_flag = 1;
    else if (wr && sel == 3 && (data % 2) == 0) m_flag = 0;
    if (wr) begin
      if (sel == 0) begin
        m_reg = data[0]; m_inj = data[1]; m_one = data[2]; m_irq = data[3];
        cf = (data >> 4) % 32;
        m_chan = (cf > 18) ? 0 : cf;
      end else if (sel == 1) m_hi = data % 4096;
      else if (sel == 2) m_lo = data % 4096;
    end
    check(req, wd_flag, m_flag, "flag");
    check(req, wd_irq, m_flag && m_irq, "irq");
  endtask

  task automatic wr_cfg(input int sel, input int data, input string req);
    cycle(1, sel, data, 0, 0, 0, 0, req);
  endtask

  task automatic res(input int code, input int ch, input bit inj, input string req);
    cycle(0, 0, 0, 1, code, ch, inj, req);
  endtask

  task automatic clear_flag(input string req);
    wr_cfg(3, 0, req);
  endtask

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_sel = 0; cfg_wdata = 0;
    res_valid = 0; res_data = 0; res_chan = 0; res_inj = 0;
    m_hi = 4095; m_lo = 0; m_chan = 0;
    m_reg = 0; m_inj = 0; m_one = 0; m_irq = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", wd_flag, 0, "flag in reset");
    check("R1", wd_irq, 0, "irq in reset");
    @(negedge clk) rst_n = 1;
    repeat (3) cycle(0, 0, 0, 0, 0, 0, 0, "R1");

    // R1: default window covers the whole code range
    wr_cfg(0, 'h3, "R1");
    res(0, 1, 0, "R1"); res(4095, 2, 1, "R1");

    // R2/R3: window 0x100..0x700
    wr_cfg(1, 'h700, "R2"); wr_cfg(2, 'h100, "R2");
    res('h700, 0, 0, "R3"); res('h100, 0, 1, "R3");
    res('h701, 3, 0, "R2"); res(0, 0, 0, "R8");
    clear_flag("R8");
    res('h0FF, 4, 1, "R2"); clear_flag("R8");

    // R8: writing 1 to status keeps the flag
    res('h800, 5, 0, "R2"); wr_cfg(3, 1, "R8"); cycle(0, 0, 0, 0, 0, 0, 0, "R8");
    // R8: violation together with a clear keeps it set
    cycle(1, 3, 0, 1, 'hFFF, 6, 0, "R8"); clear_flag("R8");

    // R10: garbage on the result lines without a strobe
    cycle(0, 0, 0, 0, 'hFFF, 0, 0, "R10"); cycle(0, 0, 0, 0, 0, 7, 1, "R10");

    // R4: upper bits dropped on bound writes
    wr_cfg(1, 'hF800, "R4");
    res('h800, 0, 0, "R4"); res('h801, 0, 0, "R4"); clear_flag("R4");
    wr_cfg(2, 'hA050, "R4");
    res('h050, 0, 0, "R4"); res('h04F, 0, 0, "R4"); clear_flag("R4");

    // R5: group gating
    wr_cfg(0, 'h1, "R5");
    res('hFFF, 0, 1, "R5"); res('hFFF, 0, 0, "R5"); clear_flag("R5");
    wr_cfg(0, 'h2, "R5");
    res('hFFF, 0, 0, "R5"); res(0, 0, 1, "R5"); clear_flag("R5");
    wr_cfg(0, 'h0, "R5");
    res('hFFF, 0, 0, "R5"); res(0, 9, 1, "R5");

    // R6: single channel 7, both groups
    wr_cfg(0, 'h7 | (7 << 4), "R6");
    res('hFFF, 6, 0, "R6"); res('hFFF, 8, 1, "R6");
    res('hFFF, 7, 1, "R6"); clear_flag("R6");
    res(0, 7, 0, "R6"); clear_flag("R6");
    // R6: all-channel mode again
    wr_cfg(0, 'h3, "R6"); res('hFFF, 31, 0, "R6"); clear_flag("R6");

    // R7: channel 20 stored as 0; channel 18 kept
    wr_cfg(0, 'h7 | (20 << 4), "R7");
    res('hFFF, 20, 0, "R7"); res('hFFF, 0, 0, "R7"); clear_flag("R7");
    wr_cfg(0, 'h7 | (18 << 4), "R7");
    res('hFFF, 0, 0, "R7"); res('hFFF, 18, 1, "R7"); clear_flag("R7");

    // R9: interrupt gating as a level
    wr_cfg(0, 'hB, "R9");
    res('hFFF, 1, 0, "R9"); cycle(0, 0, 0, 0, 0, 0, 0, "R9");
    wr_cfg(0, 'h3, "R9"); wr_cfg(0, 'hB, "R9");
    clear_flag("R9"); cycle(0, 0, 0, 0, 0, 0, 0, "R9");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule